// File: doc/BRIEF.md
# Tone Detection Status Collector

This block gathers the result codes of three receive-path detectors: a sub-audio tone decoder, a digital coded squelch (DCS) decoder and a selective-call tone decoder. It packs them into one registered 16-bit tones word that the host reads. The word is masked by the per-detector mode enables, by transmit mode and by a priority rule: a DCS or special condition blanks the sub-audio index.

Three sticky change flags track the masked fields from one clock to the next. A change in the sub-audio index is not flagged when it goes from "no tone" to "invalid tone". The host clears all flags by reading the status register. The interrupt line is the OR of the flags, each gated by its own enable bit. The flags sit at status bits 11 (sub-audio), 12 (DCS) and 13 (selective call).

Top module: `tone_status_collector`

## Requirements
- R1: The tones word is registered and updates one clock after its inputs. Bits 15:11 hold the selective-call index, 10:8 the DCS status, 5:0 the sub-audio index, and 7:6 always read 0.
- R2: While transmit mode is high on a clock edge, the tones word registered on that edge is all zeros.
- R3: Each field reads 0 while its own enable (sub-audio, DCS, selective call) is low.
- R4: Only the DCS codes 000 (none), 010 (sequence), 011 (inverted sequence) and 111 (turn-off tone) are reported. The reserved codes 001, 100, 101 and 110 are reported as 000.
- R5: When bits 10:8 are non-zero, bits 5:0 read 000000.
- R6: A change of bits 5:0 between consecutive clocks sets the sub-audio change flag on the following edge.
- R7: A change of bits 5:0 from 0 to 55 (binary 110111, invalid tone) does not set the sub-audio change flag.
- R8: A change of bits 10:8 between consecutive clocks sets the DCS change flag on the following edge.
- R9: A change of bits 15:11 between consecutive clocks sets the selective-call change flag on the following edge.
- R10: The flags stay set until a clock edge with the status read strobe high clears them. A new change seen on that same edge keeps its flag set.
- R11: irq_o is high exactly when some flag is set and its enable bit is set. Enable bit 0 gates sub-audio, bit 1 DCS and bit 2 selective call.
- R12: A field that is forced to zero by transmit mode or by a disabled enable counts as a change when its previous value was non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| subaud_code_i | input | 6 | Sub-audio detector result index |
| dcs_code_i | input | 3 | DCS/special detector status code |
| selcall_code_i | input | 5 | Selective-call detector result index |
| subaud_en_i | input | 1 | Sub-audio detection mode enable |
| dcs_en_i | input | 1 | DCS detection mode enable |
| selcall_en_i | input | 1 | Selective-call detection mode enable |
| tx_mode_i | input | 1 | Transmit mode, blanks the whole word |
| status_rd_i | input | 1 | Host read strobe of the status register |
| flag_irq_en_i | input | 3 | Per-flag interrupt enables |
| tones_word_o | output | 16 | Packed tones word |
| subaud_chg_o | output | 1 | Sub-audio change flag (status bit 11) |
| dcs_chg_o | output | 1 | DCS change flag (status bit 12) |
| selcall_chg_o | output | 1 | Selective-call change flag (status bit 13) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong masking or priority state shows on tones_word_o one clock after the inputs. A stale previous-value register shows as a missing or spurious change flag two clocks after the input change. A corrupt flag register can stay hidden until the host reads or irq_o rises, so every scenario samples the flags and irq_o directly at the ports. The read strobe is also made to collide with a fresh event, so a lost set-versus-clear priority appears within one cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int SEL_W  = 5;
  localparam int DCS_W  = 3;
  localparam int RSV_W  = 2;
  localparam int SUB_W  = 6;
  localparam int WORD_W = SEL_W + DCS_W + RSV_W + SUB_W;

  localparam int NUM_FLAGS = 3;
  localparam int FLG_SUB   = 0;
  localparam int FLG_DCS   = 1;
  localparam int FLG_SEL   = 2;

  localparam logic [SUB_W-1:0] SUB_NONE    = '0;
  localparam logic [SUB_W-1:0] SUB_INVALID = 6'd55;

  typedef enum logic [DCS_W-1:0] {
    DCS_IDLE    = 3'b000,
    DCS_SEQ     = 3'b010,
    DCS_SEQ_INV = 3'b011,
    DCS_TURNOFF = 3'b111
  } dcs_stat_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DCS_W-1:0] dcs;
    logic [RSV_W-1:0] rsv;
    logic [SUB_W-1:0] sub;
  } tones_word_t;

  // Legal DCS codes pass; reserved codes collapse to idle.
  function automatic logic [DCS_W-1:0] dcs_filter(input logic [DCS_W-1:0] code);
    case (code)
      DCS_SEQ, DCS_SEQ_INV, DCS_TURNOFF: return code;
      default:                           return DCS_IDLE;
    endcase
  endfunction

  // Field change with one suppressed transition (from -> to).
  function automatic logic quiet_change(input logic [SUB_W-1:0] prev,
                                        input logic [SUB_W-1:0] cur,
                                        input logic [SUB_W-1:0] from_v,
                                        input logic [SUB_W-1:0] to_v);
    return (prev != cur) && !((prev == from_v) && (cur == to_v));
  endfunction
endpackage

// File: rtl/tsc_field_mask.sv
module tsc_field_mask
  import tsc_pkg::*;
(
  input  logic [SUB_W-1:0] subaud_code_i,
  input  logic [DCS_W-1:0] dcs_code_i,
  input  logic [SEL_W-1:0] selcall_code_i,
  input  logic             subaud_en_i,
  input  logic             dcs_en_i,
  input  logic             selcall_en_i,
  input  logic             tx_mode_i,
  output tones_word_t      masked_o
);
  logic [DCS_W-1:0] dcs_legal;
  logic             dcs_active;

  assign dcs_legal  = dcs_en_i ? dcs_filter(dcs_code_i) : '0;
  assign dcs_active = (dcs_legal != '0);

  always_comb begin
    masked_o = '0;
    if (!tx_mode_i) begin
      masked_o.sel = selcall_en_i ? selcall_code_i : '0;
      masked_o.dcs = dcs_legal;
      masked_o.sub = (subaud_en_i && !dcs_active) ? subaud_code_i : '0;
    end
  end
endmodule

// File: rtl/tsc_change_track.sv
module tsc_change_track #(
  parameter int W = 4,
  parameter bit HAS_QUIET = 1'b0,
  parameter logic [W-1:0] QUIET_FROM = '0,
  parameter logic [W-1:0] QUIET_TO   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] prev_o,
  output logic         evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= cur_i;
  end

  generate
    if (HAS_QUIET) begin : g_quiet
      assign evt_o = (prev_o != cur_i) &&
                     !((prev_o == QUIET_FROM) && (cur_i == QUIET_TO));
    end else begin : g_plain
      assign evt_o = (prev_o != cur_i);
    end
  endgenerate
endmodule

// File: rtl/tsc_sticky_flags.sv
module tsc_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i)    flags_o[i] <= 1'b0;
    end
  end

  assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/tone_status_collector.sv
module tone_status_collector
  import tsc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SUB_W-1:0]     subaud_code_i,
  input  logic [DCS_W-1:0]     dcs_code_i,
  input  logic [SEL_W-1:0]     selcall_code_i,
  input  logic                 subaud_en_i,
  input  logic                 dcs_en_i,
  input  logic                 selcall_en_i,
  input  logic                 tx_mode_i,
  input  logic                 status_rd_i,
  input  logic [NUM_FLAGS-1:0] flag_irq_en_i,
  output logic [WORD_W-1:0]    tones_word_o,
  output logic                 subaud_chg_o,
  output logic                 dcs_chg_o,
  output logic                 selcall_chg_o,
  output logic                 irq_o
);
  tones_word_t            masked;
  tones_word_t            word_q;
  logic [SUB_W-1:0]       sub_prev;
  logic [DCS_W-1:0]       dcs_prev;
  logic [SEL_W-1:0]       sel_prev;
  logic [NUM_FLAGS-1:0]   evt_vec;
  logic [NUM_FLAGS-1:0]   flags;

  tsc_field_mask u_mask (
    .subaud_code_i (subaud_code_i),
    .dcs_code_i    (dcs_code_i),
    .selcall_code_i(selcall_code_i),
    .subaud_en_i   (subaud_en_i),
    .dcs_en_i      (dcs_en_i),
    .selcall_en_i  (selcall_en_i),
    .tx_mode_i     (tx_mode_i),
    .masked_o      (masked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= masked;
  end

  tsc_change_track #(
    .W(SUB_W), .HAS_QUIET(1'b1), .QUIET_FROM(SUB_NONE), .QUIET_TO(SUB_INVALID)
  ) u_trk_sub (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(word_q.sub),
    .prev_o(sub_prev), .evt_o(evt_vec[FLG_SUB])
  );

  tsc_change_track #(.W(DCS_W)) u_trk_dcs (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(word_q.dcs),
    .prev_o(dcs_prev), .evt_o(evt_vec[FLG_DCS])
  );

  tsc_change_track #(.W(SEL_W)) u_trk_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .cur_i(word_q.sel),
    .prev_o(sel_prev), .evt_o(evt_vec[FLG_SEL])
  );

  tsc_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_vec),
    .clr_i  (status_rd_i),
    .en_i   (flag_irq_en_i),
    .flags_o(flags),
    .irq_o  (irq_o)
  );

  assign tones_word_o  = word_q;
  assign subaud_chg_o  = flags[FLG_SUB];
  assign dcs_chg_o     = flags[FLG_DCS];
  assign selcall_chg_o = flags[FLG_SEL];
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker
  import tsc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tx_mode_i,
  input logic                 status_rd_i,
  input logic [NUM_FLAGS-1:0] flag_irq_en_i,
  input logic [WORD_W-1:0]    tones_word_o,
  input logic                 subaud_chg_o,
  input logic                 dcs_chg_o,
  input logic                 selcall_chg_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] evt_vec
);
  localparam int SUB_LO = 0;
  localparam int DCS_LO = SUB_W + RSV_W;
  localparam int SEL_LO = DCS_LO + DCS_W;

  logic [SUB_W-1:0] w_sub;
  logic [DCS_W-1:0] w_dcs;
  logic [SEL_W-1:0] w_sel;
  assign w_sub = tones_word_o[SUB_LO +: SUB_W];
  assign w_dcs = tones_word_o[DCS_LO +: DCS_W];
  assign w_sel = tones_word_o[SEL_LO +: SEL_W];

  assert_rsv_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tones_word_o[DCS_LO-1:SUB_W] == '0);

  assert_tx_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mode_i |=> tones_word_o == '0);

  assert_dcs_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_dcs == 3'b000) || (w_dcs == 3'b010) || (w_dcs == 3'b011) || (w_dcs == 3'b111));

  assert_dcs_blanks_sub_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_dcs != '0) |-> (w_sub == '0));

  assert_sub_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_sub != $past(w_sub)) && !($past(w_sub) == SUB_NONE && w_sub == SUB_INVALID)
      |=> subaud_chg_o);

  assert_quiet_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!subaud_chg_o && w_sub == SUB_INVALID && $past(w_sub) == SUB_NONE) |=> !subaud_chg_o);

  assert_dcs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_dcs != $past(w_dcs)) |=> dcs_chg_o);

  assert_sel_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_sel != $past(w_sel)) |=> selcall_chg_o);

  assert_read_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && evt_vec == '0) |=> !subaud_chg_o && !dcs_chg_o && !selcall_chg_o);

  assert_irq_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_irq_en_i == '0) |-> !irq_o);

  assert_irq_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (subaud_chg_o || dcs_chg_o || selcall_chg_o));
endmodule

bind tone_status_collector tsc_checker u_tsc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_mode_i    (tx_mode_i),
  .status_rd_i  (status_rd_i),
  .flag_irq_en_i(flag_irq_en_i),
  .tones_word_o (tones_word_o),
  .subaud_chg_o (subaud_chg_o),
  .dcs_chg_o    (dcs_chg_o),
  .selcall_chg_o(selcall_chg_o),
  .irq_o        (irq_o),
  .evt_vec      (evt_vec)
);

// File: tb/tone_status_collector_tb.sv
module tone_status_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  sub_c = '0;
  logic [2:0]  dcs_c = '0;
  logic [4:0]  sel_c = '0;
  logic        sub_en = 1'b0, dcs_en = 1'b0, sel_en = 1'b0;
  logic        tx = 1'b0, rd = 1'b0;
  logic [2:0]  irq_en = '0;
  logic [15:0] word;
  logic        f_sub, f_dcs, f_sel, irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  tone_status_collector dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .subaud_code_i(sub_c), .dcs_code_i(dcs_c), .selcall_code_i(sel_c),
    .subaud_en_i(sub_en), .dcs_en_i(dcs_en), .selcall_en_i(sel_en),
    .tx_mode_i(tx), .status_rd_i(rd), .flag_irq_en_i(irq_en),
    .tones_word_o(word), .subaud_chg_o(f_sub), .dcs_chg_o(f_dcs),
    .selcall_chg_o(f_sel), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected word built field by field from the requirements.
  function automatic logic [15:0] model_word(input logic [4:0] s, input logic [2:0] d,
                                             input logic [5:0] a);
    logic [2:0] dd;
    logic [5:0] aa;
    logic [4:0] ss;
    if (tx) return 16'h0000;
    ss = sel_en ? s : 5'd0;
    dd = 3'd0;
    if (dcs_en && (d == 3'd2 || d == 3'd3 || d == 3'd7)) dd = d;
    aa = (sub_en && dd == 3'd0) ? a : 6'd0;
    return {ss, dd, 2'b00, aa};
  endfunction

  // Apply inputs at a falling edge, then sample after two rising edges.
  task automatic apply(input logic [4:0] s, input logic [2:0] d, input logic [5:0] a);
    sel_c = s; dcs_c = d; sub_c = a;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic clear_flags();
    rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [15:0] fl();
    return {13'd0, f_sel, f_dcs, f_sub};
  endfunction

  task automatic t_reset();
    chk("R1 reset word", word, 16'h0000);
    chk("R10 reset flags", fl(), 16'h0000);
    chk("R11 reset irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_layout();
    sub_en = 1; dcs_en = 1; sel_en = 1; irq_en = 3'b111;
    apply(5'd19, 3'd0, 6'd12);
    chk("R1 layout", word, {5'd19, 3'd0, 2'b00, 6'd12});
    chk("R1 model", word, model_word(5'd19, 3'd0, 6'd12));
    chk("R6 R9 flags", fl(), 16'h0005);
    chk("R11 irq all enabled", {15'd0, irq}, 16'h0001);
    clear_flags();
    chk("R10 read clears", fl(), 16'h0000);
  endtask

  task automatic t_invalid();
    apply(5'd19, 3'd0, 6'd0);
    clear_flags();
    apply(5'd19, 3'd0, 6'd55);
    chk("R1 invalid code word", word, {5'd19, 3'd0, 2'b00, 6'd55});
    chk("R7 no flag 0->55", fl(), 16'h0000);
    apply(5'd19, 3'd0, 6'd0);
    chk("R6 flag 55->0", fl(), 16'h0001);
    clear_flags();
    apply(5'd19, 3'd0, 6'd12);
    chk("R6 flag 0->12", fl(), 16'h0001);
    clear_flags();
    apply(5'd19, 3'd0, 6'd55);
    chk("R6 flag 12->55", fl(), 16'h0001);
    clear_flags();
  endtask

  task automatic t_dcs();
    apply(5'd19, 3'd0, 6'd12);
    clear_flags();
    apply(5'd19, 3'd2, 6'd12);
    chk("R5 dcs blanks sub", word, {5'd19, 3'd2, 2'b00, 6'd0});
    chk("R8 dcs flag", fl(), 16'h0003);
    clear_flags();
    apply(5'd19, 3'd7, 6'd12);
    chk("R4 turn-off code", word, {5'd19, 3'd7, 2'b00, 6'd0});
    chk("R8 dcs flag 2->7", fl(), 16'h0002);
    clear_flags();
    apply(5'd19, 3'd5, 6'd12);
    chk("R4 reserved dcs code", word, {5'd19, 3'd0, 2'b00, 6'd12});
    chk("R4 model", word, model_word(5'd19, 3'd5, 6'd12));
    clear_flags();
    apply(5'd19, 3'd1, 6'd12);
    chk("R4 reserved 001 no change", fl(), 16'h0000);
  endtask

  task automatic t_enables();
    apply(5'd7, 3'd3, 6'd9);
    clear_flags();
    sel_en = 0;
    apply(5'd7, 3'd3, 6'd9);
    chk("R3 selcall disabled", word, {5'd0, 3'd3, 2'b00, 6'd0});
    chk("R12 R9 disable counts", fl(), 16'h0004);
    clear_flags();
    dcs_en = 0;
    apply(5'd7, 3'd3, 6'd9);
    chk("R3 dcs disabled", word, {5'd0, 3'd0, 2'b00, 6'd9});
    sub_en = 0;
    apply(5'd7, 3'd3, 6'd9);
    chk("R3 all disabled", word, 16'h0000);
    sub_en = 1; dcs_en = 1; sel_en = 1;
    apply(5'd22, 3'd0, 6'd30);
    clear_flags();
  endtask

  task automatic t_tx();
    tx = 1;
    apply(5'd22, 3'd0, 6'd30);
    chk("R2 tx blanks word", word, 16'h0000);
    chk("R12 tx counts as change", fl(), 16'h0005);
    tx = 0;
    apply(5'd22, 3'd0, 6'd30);
    chk("R1 after tx", word, model_word(5'd22, 3'd0, 6'd30));
    clear_flags();
  endtask

  task automatic t_irq();
    apply(5'd1, 3'd0, 6'd30);
    irq_en = 3'b000;
    #1;
    chk("R11 flag set irq masked", {15'd0, irq}, 16'h0000);
    irq_en = 3'b100;
    #1;
    chk("R11 selcall enable", {15'd0, irq}, 16'h0001);
    irq_en = 3'b011;
    #1;
    chk("R11 other enables", {15'd0, irq}, 16'h0000);
    irq_en = 3'b111;
    clear_flags();
  endtask

  task automatic t_collide();
    sel_c = 5'd9;
    @(posedge clk); @(negedge clk);
    rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
    chk("R10 set wins over read", fl(), 16'h0004);
    clear_flags();
    chk("R10 later read clears", fl(), 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_invalid();
    t_dcs();
    t_enables();
    t_tx();
    t_irq();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule